// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog whose enable can be set once and never cleared by software. It is built around a free-running counter (14 bits by default) that sits idle after reset. Software arms it by writing a two-byte key, first `0x1E` and then `0xE1`, as two consecutive accepted bytes on its write port. From then on the only way to keep the watchdog quiet is to write the same key again before the counter runs past its top value. A system reset is the only thing that disarms it.

When the counter wraps, the block raises `rst_out` for a fixed number of clock cycles (96 by default), holding the counter at zero meanwhile, and then lets the count start again from zero. The counter steps only in cycles where the clock enable `tick_en` is high and the power-down indicator is low. The idle indicator has no effect: the count goes on during idle.

The write port is a valid/ready stream of single bytes. The block never applies back-pressure: `wr_ready` is high in every cycle after reset, so each cycle with `wr_valid` high transfers one byte. Cycles without a transfer between the two key bytes do not break the key. Only the next accepted byte counts.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed and `rst_out` is low. A disarmed watchdog never raises `rst_out`, and a reset given while armed disarms it again.
- R2: An accepted byte `0x1E` followed by the very next accepted byte `0xE1` arms the watchdog at the clock edge that takes `0xE1`. The counter is zero after that edge, and `rst_out` rises 2^CNT_W advancing edges later.
- R3: Once `0x1E` has been accepted, any next accepted byte other than `0xE1` (including `0x1E` itself) drops the partial key. The byte after it must begin again with `0x1E`.
- R4: Accepted bytes outside a correct key, in any order, leave a disarmed watchdog disarmed.
- R5: Once armed, no write stream disarms the watchdog.
- R6: A complete key accepted while armed clears the counter to zero at that edge, which pushes the next wrap back by a full 2^CNT_W advancing edges.
- R7: The counter advances only on edges where `tick_en` is high and `pdown_i` is low. `idle_i` has no effect on the count.
- R8: On a wrap, `rst_out` is high for exactly PULSE_CYC (default 96) clock cycles. The counter is held at zero throughout. The next wrap follows 2^CNT_W advancing edges after `rst_out` falls.
- R9: When a key completes on the same edge at which the counter would wrap, the service wins: the counter clears and `rst_out` stays low.
- R10: `wr_ready` is high in every cycle after reset, including while `rst_out` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick_en | input | 1 | Counter clock enable |
| idle_i | input | 1 | Idle-mode indicator (count continues) |
| pdown_i | input | 1 | Power-down indicator (count frozen) |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte accepted (always high) |
| rst_out | output | 1 | Reset-out pulse |

## Verification
Two functions can collide on a single edge: the second key byte that services the counter, and the counter's own wrap. The bench arms the watchdog, waits exactly long enough that `0xE1` is taken on the edge where the count would roll over, and then checks that `rst_out` does not rise until a full period after that edge. Hold-off by power-down and by a low clock enable is judged the same way, from the cycle in which `rst_out` finally rises.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic {
    KEY_WAIT = 1'b0,
    KEY_HALF = 1'b1
  } key_st_e;

  localparam logic [7:0] KEY_OPEN_DEF  = 8'h1E;
  localparam logic [7:0] KEY_CLOSE_DEF = 8'hE1;
  localparam int         CNT_W_DEF     = 14;
  localparam int         PULSE_DEF     = 96;
endpackage

// File: rtl/wdk_key_seq.sv
module wdk_key_seq
  import wdk_pkg::*;
#(
  parameter logic [7:0] KEY_OPEN  = KEY_OPEN_DEF,
  parameter logic [7:0] KEY_CLOSE = KEY_CLOSE_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] byte_in,
  output logic       seq_done,
  output logic       armed
);
  key_st_e st_q;

  assign seq_done = (st_q == KEY_HALF) && fire && (byte_in == KEY_CLOSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= KEY_WAIT;
      armed <= 1'b0;
    end else begin
      if (fire) begin
        if (st_q == KEY_WAIT)
          st_q <= (byte_in == KEY_OPEN) ? KEY_HALF : KEY_WAIT;
        else
          st_q <= KEY_WAIT;
      end
      if (seq_done)
        armed <= 1'b1;
    end
  end

  // R5: enable is sticky until reset
  p_armed_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R2: arming happens only on an accepted closing byte
  p_arm_on_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(fire && byte_in == KEY_CLOSE));

  // R3: a wrong second byte drops the partial key
  p_abandon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KEY_HALF && fire && byte_in != KEY_CLOSE) |=> (st_q == KEY_WAIT));
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int CNT_W = wdk_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  assign wrap = adv && !clr && (cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (adv)
      cnt <= cnt + 1'b1;
  end

  // R6: a service leaves the count at zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R7: without an advance the count holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt));
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_CYC = wdk_pkg::PULSE_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      left_q <= LAST;
    end else if (busy) begin
      if (left_q == '0)
        busy <= 1'b0;
      else
        left_q <= left_q - 1'b1;
    end
  end

  // R8: pulse keeps going while cycles remain
  p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left_q != '0) |=> busy);

  // R8: pulse ends after the last cycle
  p_pulse_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left_q == '0 && !start) |=> !busy);

  // R8: a start loads the full length
  p_pulse_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && left_q == LAST));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdk_pkg::*;
#(
  parameter int         CNT_W     = CNT_W_DEF,
  parameter int         PULSE_CYC = PULSE_DEF,
  parameter logic [7:0] KEY_OPEN  = KEY_OPEN_DEF,
  parameter logic [7:0] KEY_CLOSE = KEY_CLOSE_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       idle_i,
  input  logic       pdown_i,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       rst_out
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             seq_done;
  logic             armed;
  logic             adv;
  logic             wrap;
  logic [CNT_W-1:0] cnt;

  assign wr_ready = 1'b1;

  wdk_key_seq #(
    .KEY_OPEN  (KEY_OPEN),
    .KEY_CLOSE (KEY_CLOSE)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (wr_valid && wr_ready),
    .byte_in  (wr_data),
    .seq_done (seq_done),
    .armed    (armed)
  );

  // Power-down freezes; idle does not. Counting pauses for the pulse.
  assign adv = armed && tick_en && !pdown_i && !rst_out;

  wdk_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .clr   (seq_done),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  wdk_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wrap),
    .busy  (rst_out)
  );

  // R1: no reset-out while disarmed
  p_quiet_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !rst_out);

  // R9: a service on the wrap edge suppresses the pulse
  p_kick_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !rst_out) |=> !rst_out);

  // R7: idle does not stop an armed, enabled counter
  p_idle_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && armed && tick_en && !pdown_i && !rst_out && !seq_done && cnt != CNT_TOP)
      |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R7: power-down freezes the count
  p_pdown_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_i && !seq_done) |=> $stable(cnt));

  // R10: the port never stalls
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready);
endmodule

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
  localparam int TB_W   = 8;
  localparam int PULSE  = 96;
  localparam int PERIOD = 1 << TB_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       idle_i = 1'b0;
  logic       pdown_i = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic       rst_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.CNT_W(TB_W), .PULSE_CYC(PULSE)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .idle_i   (idle_i),
    .pdown_i  (pdown_i),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .rst_out  (rst_out)
  );

  // {byte0, byte1, byte2, write index (1..3) that arms, 0 = never}
  localparam logic [25:0] VEC [8] = '{
    {8'h1E, 8'hE1, 8'h00, 2'd2},
    {8'h1E, 8'h00, 8'hE1, 2'd0},
    {8'h1E, 8'h1E, 8'hE1, 2'd0},
    {8'h00, 8'h1E, 8'hE1, 2'd3},
    {8'hE1, 8'h1E, 8'h00, 2'd0},
    {8'h1E, 8'hE1, 8'h1E, 2'd2},
    {8'h55, 8'hAA, 8'hE1, 2'd0},
    {8'h1E, 8'h55, 8'h1E, 2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered at a negedge; the byte is taken at the following posedge.
  task automatic wr(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
  endtask

  // n = 1 is the negedge right after the last write edge; 0 = no rise.
  task automatic run_until_rise(input int maxn, output int n);
    n = 0;
    wr_valid = 1'b0;
    for (int i = 1; i <= maxn; i++) begin
      if (rst_out) begin
        n = i;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_valid = 1'b0;
    tick_en = 1'b1;
    pdown_i = 1'b0;
    idle_i  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: bench did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, h, l;
    do_reset();
    @(negedge clk);
    check("R1 reset rst_out", int'(rst_out), 0);
    check("R10 ready after reset", int'(wr_ready), 1);

    // Table walk: key orderings R2 R3 R4; idle high on odd entries (R7)
    for (int v = 0; v < 8; v++) begin
      int exp_n;
      do_reset();
      idle_i = v[0];
      wr(VEC[v][25:18]);
      wr(VEC[v][17:10]);
      wr(VEC[v][9:2]);
      exp_n = (VEC[v][1:0] == 2'd0) ? 0 : (PERIOD - 2 + int'(VEC[v][1:0]));
      run_until_rise(PERIOD + 150, n);
      check($sformatf("R2/R3/R4 vector %0d first rise", v), n, exp_n);
    end

    // R8: pulse width and period after restart; R10 during pulse
    do_reset();
    wr(8'h1E); wr(8'hE1);
    run_until_rise(PERIOD + 10, n);
    check("R2 arm to wrap", n, PERIOD + 1);
    check("R10 ready during pulse", int'(wr_ready), 1);
    h = 0;
    while (rst_out && h < 1000) begin h++; @(negedge clk); end
    check("R8 pulse length", h, PULSE);
    l = 0;
    while (!rst_out && l < 1000) begin l++; @(negedge clk); end
    check("R8 restart period", l, PERIOD);

    // R6: service part-way through pushes the wrap back
    do_reset();
    wr(8'h1E); wr(8'hE1);
    wr_valid = 1'b0;
    repeat (150) @(negedge clk);
    wr(8'h1E); wr(8'hE1);
    run_until_rise(PERIOD + 10, n);
    check("R6 service restarts count", n, PERIOD + 1);

    // R5 and R3 while armed: junk and a broken key neither disarm nor service
    do_reset();
    wr(8'h1E); wr(8'hE1); wr(8'h00); wr(8'h1E); wr(8'h5A);
    run_until_rise(PERIOD + 10, n);
    check("R5 still armed after junk", n, PERIOD - 2);

    // R7: power-down freezes the count
    do_reset();
    wr(8'h1E); wr(8'hE1);
    wr_valid = 1'b0;
    pdown_i = 1'b1;
    repeat (99) @(negedge clk);
    pdown_i = 1'b0;
    run_until_rise(PERIOD + 10, n);
    check("R7 power-down hold", n, PERIOD + 1);

    // R7: low clock enable freezes the count
    do_reset();
    wr(8'h1E); wr(8'hE1);
    wr_valid = 1'b0;
    tick_en = 1'b0;
    repeat (99) @(negedge clk);
    tick_en = 1'b1;
    run_until_rise(PERIOD + 10, n);
    check("R7 tick_en low hold", n, PERIOD + 1);

    // R9: key completes on the wrap edge
    do_reset();
    wr(8'h1E); wr(8'hE1);
    wr_valid = 1'b0;
    repeat (PERIOD - 2) @(negedge clk);
    wr(8'h1E); wr(8'hE1);
    run_until_rise(PERIOD + 10, n);
    check("R9 service beats wrap", n, PERIOD + 1);

    // R1: reset while armed disarms
    do_reset();
    wr(8'h1E); wr(8'hE1);
    wr_valid = 1'b0;
    repeat (100) @(negedge clk);
    do_reset();
    @(negedge clk);
    run_until_rise(PERIOD * 2, n);
    check("R1 reset disarms", n, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule